// File: doc/BRIEF.md
# Flag-Triggered Word Correction Controller

This block is a sequencer that sits next to one word of a content-addressable memory. The word is 32 bits wide and is seen as four 8-bit symbols, numbered 0 to 3 from the least significant end. Two 9-bit check values are kept with it. Each check value is the plain integer sum of two symbols: symbols 0 and 2 form group A, and symbols 1 and 3 form group B. The same adder pair that produces these sums for the write path is also used to compute the syndrome during correction, so that no second set of adders is needed.

Current sensors outside the block raise a 32-bit per-column upset flag vector. Bit i of that vector marks bit i of the word as possibly upset. When no flag is raised, a lookup returns the stored word as it is, one cycle later. When any flag is raised, the controller first captures the word, its check values and the flags. It then recomputes both sums and subtracts the stored sums, which shows the groups that are in error. It inverts the flagged bits, but only inside the groups whose difference is nonzero. Finally it issues a one-cycle write-back of the repaired word. The sums cannot locate bits by themselves; the flags do that.

While a correction runs, the block reports busy and does not accept lookups. Flags that arrive during that time are collected and serviced once the current write-back has finished.

Top module: `dmc_cam_fixer`

## Requirements
- R1: After reset, `busy`, `out_valid` and `wb_en` are all 0.
- R2: While `busy` is 0, `enc_chk[8:0]` equals the integer sum of `enc_data[7:0]` and `enc_data[23:16]`, and `enc_chk[17:9]` equals the integer sum of `enc_data[15:8]` and `enc_data[31:24]`.
- R3: A `lookup` sampled while the block is idle and no flag is present, either on the input or held as pending, gives `out_valid` = 1 for exactly the next cycle. In that cycle `out_word` equals the `word_in` that was sampled.
- R4: A nonzero flag sampled while idle starts a correction. `busy` is 1 for exactly the next four cycles.
- R5: `wb_en` is 1 for exactly one cycle, which is the third cycle of `busy`.
- R6: In the write-back cycle, `wb_word` equals the captured word with every flagged bit inverted, in each group whose recomputed sum differs from the captured check value. A group covers the bits 8s to 8s+7 of its two symbols s.
- R7: Flagged bits in a group whose recomputed sum equals the stored sum are left unchanged in `wb_word`. This covers false flags and upsets that cancel in the sum.
- R8: A `lookup` that is sampled while `busy` is 1, or in the same cycle that a correction starts, produces no `out_valid`.
- R9: Flags sampled while `busy` is 1 are kept as pending. After `busy` falls, it stays 0 for one cycle, and then a new correction starts using those flags.
- R10: `wb_word` differs from the captured word only in bit positions that are set in the flag vector in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enc_data | input | 32 | Data word to be encoded on the write path |
| enc_chk | output | 18 | Check sums of `enc_data` (group B in the upper 9 bits), valid while not busy |
| lookup | input | 1 | Read request for the stored word |
| word_in | input | 32 | Stored word as read from the memory |
| chk_in | input | 18 | Stored check sums, with the same layout as `enc_chk` |
| err_flag | input | 32 | Per-column upset flags; bit i marks word bit i |
| busy | output | 1 | Correction in progress; lookups are refused |
| out_valid | output | 1 | `out_word` carries a lookup result |
| out_word | output | 32 | Lookup result |
| wb_en | output | 1 | Write `wb_word` back into the memory word |
| wb_word | output | 32 | Corrected word for write-back |

## Verification
The assertions check the sequencing properties on every cycle:
- the single-cycle write-back pulse;
- the start of a correction from a flag;
- the silence of `out_valid` while busy;
- the retention of late flags as pending;
- the rule that write-back never changes an unflagged bit.

Only the bench scenarios can show that the data is right. They show that a repaired word matches the original, that cancelling upsets and false flags are left alone, and that the encoder sums are correct. They also show the exact one-cycle gap before a pending correction, by comparing against a behavioural model while storage is upset between and during corrections.

// File: rtl/dmc_cam_fixer_pkg.sv
package dmc_cam_fixer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SYN  = 3'd1,
    ST_COR  = 3'd2,
    ST_WB   = 3'd3,
    ST_DONE = 3'd4
  } fix_state_e;

endpackage

// File: rtl/dmc_sum_gen.sv
module dmc_sum_gen #(
  parameter  int SYM_W  = 8,
  parameter  int NSYM   = 4,
  localparam int WORD_W = SYM_W * NSYM,
  localparam int NGRP   = NSYM / 2,
  localparam int SUM_W  = SYM_W + 1,
  localparam int CHK_W  = NGRP * SUM_W
) (
  input  logic [WORD_W-1:0] word,
  output logic [CHK_W-1:0]  chk
);

  // Group g adds symbol g and symbol g+NGRP as unsigned integers.
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign chk[g*SUM_W +: SUM_W] = {1'b0, word[g*SYM_W +: SYM_W]}
                                 + {1'b0, word[(g+NGRP)*SYM_W +: SYM_W]};
  end

endmodule

// File: rtl/dmc_syndrome.sv
module dmc_syndrome #(
  parameter  int SYM_W = 8,
  parameter  int NSYM  = 4,
  localparam int NGRP  = NSYM / 2,
  localparam int SUM_W = SYM_W + 1,
  localparam int CHK_W = NGRP * SUM_W
) (
  input  logic [CHK_W-1:0] chk_calc,
  input  logic [CHK_W-1:0] chk_ref,
  output logic [NGRP-1:0]  grp_nz
);

  // Integer difference per group; any nonzero value marks the group in error.
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [SUM_W:0] diff;
    assign diff      = {1'b0, chk_calc[g*SUM_W +: SUM_W]} - {1'b0, chk_ref[g*SUM_W +: SUM_W]};
    assign grp_nz[g] = |diff;
  end

endmodule

// File: rtl/dmc_flip.sv
module dmc_flip #(
  parameter  int SYM_W  = 8,
  parameter  int NSYM   = 4,
  localparam int WORD_W = SYM_W * NSYM,
  localparam int NGRP   = NSYM / 2
) (
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] flag,
  input  logic [NGRP-1:0]   grp_nz,
  output logic [WORD_W-1:0] fixed
);

  // Each symbol inverts its flagged bits only when its group shows a syndrome.
  for (genvar s = 0; s < NSYM; s++) begin : g_sym
    localparam int GI = s % NGRP;
    assign fixed[s*SYM_W +: SYM_W] = word[s*SYM_W +: SYM_W]
                                   ^ (flag[s*SYM_W +: SYM_W] & {SYM_W{grp_nz[GI]}});
  end

endmodule

// File: rtl/dmc_seq.sv
module dmc_seq
  import dmc_cam_fixer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output fix_state_e state
);

  fix_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE: if (start) state_nxt = ST_SYN;
      ST_SYN:  state_nxt = ST_COR;
      ST_COR:  state_nxt = ST_WB;
      ST_WB:   state_nxt = ST_DONE;
      ST_DONE: state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  // R4
  start_to_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start) |=> (state == ST_SYN));

  // R5
  wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WB) |=> (state == ST_DONE));

endmodule

// File: rtl/dmc_cam_fixer.sv
module dmc_cam_fixer
  import dmc_cam_fixer_pkg::*;
#(
  parameter  int SYM_W  = 8,
  parameter  int NSYM   = 4,
  localparam int WORD_W = SYM_W * NSYM,
  localparam int NGRP   = NSYM / 2,
  localparam int SUM_W  = SYM_W + 1,
  localparam int CHK_W  = NGRP * SUM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] enc_data,
  output logic [CHK_W-1:0]  enc_chk,
  input  logic              lookup,
  input  logic [WORD_W-1:0] word_in,
  input  logic [CHK_W-1:0]  chk_in,
  input  logic [WORD_W-1:0] err_flag,
  output logic              busy,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              wb_en,
  output logic [WORD_W-1:0] wb_word
);

  // Reset: asserted asynchronously, released on the second clock edge.
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  fix_state_e        state;
  logic [WORD_W-1:0] pend_q, pend_d, trig;
  logic [WORD_W-1:0] work_word, work_flag, fix_q, fix_d, sum_in;
  logic [CHK_W-1:0]  work_chk, chk_calc;
  logic [NGRP-1:0]   grp_nz, grp_nz_q;
  logic              in_idle, start, accept;
  logic              ld_work, ld_syn, ld_fix;

  assign in_idle = (state == ST_IDLE);
  assign trig    = err_flag | pend_q;
  assign start   = in_idle & (|trig);
  assign accept  = in_idle & ~(|trig) & lookup;
  assign ld_work = start;
  assign ld_syn  = (state == ST_SYN);
  assign ld_fix  = (state == ST_COR);
  assign pend_d  = in_idle ? '0 : (pend_q | err_flag);

  dmc_seq u_seq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (start),
    .state (state)
  );

  // Shared adders: encoder while idle, syndrome source while correcting.
  assign sum_in = in_idle ? enc_data : work_word;

  dmc_sum_gen #(.SYM_W(SYM_W), .NSYM(NSYM)) u_sum (
    .word (sum_in),
    .chk  (chk_calc)
  );

  dmc_syndrome #(.SYM_W(SYM_W), .NSYM(NSYM)) u_syn (
    .chk_calc (chk_calc),
    .chk_ref  (work_chk),
    .grp_nz   (grp_nz)
  );

  dmc_flip #(.SYM_W(SYM_W), .NSYM(NSYM)) u_flip (
    .word   (work_word),
    .flag   (work_flag),
    .grp_nz (grp_nz_q),
    .fixed  (fix_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pend_q <= '0;
    else             pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      work_word <= '0;
      work_chk  <= '0;
      work_flag <= '0;
    end else if (ld_work) begin
      work_word <= word_in;
      work_chk  <= chk_in;
      work_flag <= trig;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  grp_nz_q <= '0;
    else if (ld_syn)  grp_nz_q <= grp_nz;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  fix_q <= '0;
    else if (ld_fix)  fix_q <= fix_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_valid <= 1'b0;
    else             out_valid <= accept;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  out_word <= '0;
    else if (accept)  out_word <= word_in;
  end

  assign enc_chk = chk_calc;
  assign busy    = ~in_idle;
  assign wb_en   = (state == ST_WB);
  assign wb_word = fix_q;

  // R8
  busy_blocks_lookup_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |=> !out_valid);

  // R9
  late_flag_kept_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_DONE && (|err_flag)) |=> (|pend_q));

  // R10
  unflagged_kept_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_COR) |=> (((fix_q ^ work_word) & ~work_flag) == '0));

  // R5
  wb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wb_en |=> !wb_en);

endmodule

// File: tb/dmc_cam_fixer_tb_top.sv
`timescale 1ns/1ps
module dmc_cam_fixer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] enc_data = '0;
  logic [17:0] enc_chk;
  logic        lookup = 1'b0;
  logic [31:0] st_word = '0;
  logic [17:0] st_chk = '0;
  logic [31:0] err_flag = '0;
  logic        busy, out_valid, wb_en;
  logic [31:0] out_word, wb_word;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dmc_cam_fixer dut_i (
    .clk(clk), .rst_n(rst_n), .enc_data(enc_data), .enc_chk(enc_chk),
    .lookup(lookup), .word_in(st_word), .chk_in(st_chk), .err_flag(err_flag),
    .busy(busy), .out_valid(out_valid), .out_word(out_word),
    .wb_en(wb_en), .wb_word(wb_word)
  );

  // Memory word: the write-back replaces the data; the check sums stay.
  always @(posedge clk) if (wb_en) st_word <= wb_word;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [17:0] sums(input logic [31:0] w);
    int a, b;
    a = int'(w[7:0]) + int'(w[23:16]);
    b = int'(w[15:8]) + int'(w[31:24]);
    return {b[8:0], a[8:0]};
  endfunction

  function automatic logic [31:0] repair(input logic [31:0] w, input logic [17:0] c,
                                         input logic [31:0] f);
    logic [31:0] r;
    int a, b;
    r = w;
    a = int'(w[7:0]) + int'(w[23:16]);
    b = int'(w[15:8]) + int'(w[31:24]);
    if (a != int'(c[8:0]))  r = r ^ (f & 32'h00FF00FF);
    if (b != int'(c[17:9])) r = r ^ (f & 32'hFF00FF00);
    return r;
  endfunction

  // Behavioural reference model: phase 0 idle, 1..4 the busy cycles.
  int          m_phase = 0;
  logic [31:0] m_pend = '0, m_fix = '0, m_out = '0;
  bit          m_ov = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_pend = '0; m_ov = 0;
    end else if (m_phase == 0) begin
      m_ov = 0;
      if ((err_flag | m_pend) != 0) begin
        m_fix   = repair(st_word, st_chk, err_flag | m_pend);
        m_pend  = '0;
        m_phase = 1;
      end else if (lookup) begin
        m_ov  = 1;
        m_out = st_word;
      end
    end else begin
      m_ov    = 0;
      m_pend  = m_pend | err_flag;
      m_phase = (m_phase == 4) ? 0 : m_phase + 1;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      check("R4 busy vs model", busy, m_phase != 0);
      check("R3 out_valid vs model", out_valid, m_ov);
      if (m_ov) check("R3 out_word vs model", out_word, m_out);
      check("R5 wb_en vs model", wb_en, m_phase == 3);
      if (m_phase == 3) check("R6 wb_word vs model", wb_word, m_fix);
      if (m_phase == 0) check("R2 enc_chk vs model", enc_chk, sums(enc_data));
    end
  end

  task automatic store(input logic [31:0] w);
    @(negedge clk);
    st_word = w;
    st_chk  = sums(w);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  localparam logic [31:0] W0 = 32'hA53C960F;

  initial begin
    repeat (3) @(negedge clk);
    #3;
    check("R1 busy after reset", busy, 0);
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 wb_en after reset", wb_en, 0);
    rst_n = 1'b1;
    idle_cycles(4);

    // R2: encoder sums on the write path
    enc_data = 32'hFFFFFFFF; #3;
    check("R2 enc_chk all ones", enc_chk, {9'd510, 9'd510});
    @(negedge clk); enc_data = 32'h01020304; #3;
    check("R2 enc_chk small", enc_chk, {9'd4, 9'd6});
    @(negedge clk); enc_data = W0; #3;
    check("R2 enc_chk W0", enc_chk, sums(W0));

    // R3: lookup with no flag
    store(W0);
    @(negedge clk); lookup = 1'b1;
    @(negedge clk); lookup = 1'b0; #3;
    check("R3 out_valid", out_valid, 1);
    check("R3 out_word", out_word, W0);
    @(negedge clk); #3;
    check("R3 out_valid single cycle", out_valid, 0);

    // R6/R4/R5: upsets in group A, flagged; lookup held from the start (R8)
    @(negedge clk);
    st_word  = W0 ^ 32'h00040028;
    err_flag = 32'h00040028;
    lookup   = 1'b1;
    @(negedge clk); err_flag = '0; #3;
    check("R4 busy rises", busy, 1);
    check("R8 no out_valid on start", out_valid, 0);
    @(negedge clk); #3;
    check("R8 no out_valid while busy", out_valid, 0);
    @(negedge clk); #3;
    check("R5 wb_en in third busy cycle", wb_en, 1);
    check("R6 wb_word restored", wb_word, W0);
    @(negedge clk); #3;
    check("R5 wb_en dropped", wb_en, 0);
    check("R4 busy fourth cycle", busy, 1);
    @(negedge clk); #3;
    check("R4 busy falls", busy, 0);
    check("R6 storage restored", st_word, W0);
    @(negedge clk); lookup = 1'b0; #3;
    check("R3 lookup served after busy", out_valid, 1);
    check("R3 lookup word after fix", out_word, W0);

    // R6: whole symbol 1 upset and flagged
    @(negedge clk);
    st_word = W0 ^ 32'h0000FF00; err_flag = 32'h0000FF00;
    @(negedge clk); err_flag = '0;
    idle_cycles(5); #3;
    check("R6 full symbol repaired", st_word, W0);

    // R7: false flags in group B while group A really has an upset
    @(negedge clk);
    st_word = W0 ^ 32'h00000001; err_flag = 32'h01000101;
    @(negedge clk); err_flag = '0;
    idle_cycles(5); #3;
    check("R7 false flags ignored in clean group", st_word, W0);

    // R7: cancelling upsets, the sum of group A is unchanged
    @(negedge clk);
    st_word = W0 ^ 32'h00010001; err_flag = 32'h00010001;
    @(negedge clk); err_flag = '0;
    idle_cycles(5); #3;
    check("R7 cancelling upset left alone", st_word, W0 ^ 32'h00010001);
    store(W0);

    // R9: second upset flagged during the DONE cycle of a correction
    @(negedge clk);
    st_word = W0 ^ 32'h00000080; err_flag = 32'h00000080;
    @(negedge clk); err_flag = '0;
    idle_cycles(3);
    st_word = st_word ^ 32'h02000000; err_flag = 32'h02000000;
    @(negedge clk); err_flag = '0; #3;
    check("R9 busy low one cycle", busy, 0);
    @(negedge clk); #3;
    check("R9 pending correction starts", busy, 1);
    idle_cycles(4); #3;
    check("R9 second upset repaired", st_word, W0);
    check("R10 nothing else changed", st_word ^ W0, 0);

    idle_cycles(3);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule